// File: doc/BRIEF.md
# SD Card Clock Rate Divider

This block turns a fixed host reference clock into an SD card clock. The card clock runs at or below a requested frequency. On a start pulse it takes the host clock rate, the requested rate, a double-data-rate flag and a flag for the enhanced controller variant. It then finds the divider settings in two stages. The first stage doubles a power-of-two prescaler until the fastest rate it allows is no longer above the request. The second stage steps a linear divider from 1 up until the output rate fits. Each stage makes one comparison per clock. Every comparison is a multiply-compare, so the search needs no division.

When the search ends, a serial divider computes the rate actually achieved. The block then does four things in order. It loads the encoded prescaler and divider fields into its outputs. It turns the clock-enable bits back on. It raises the force-clock-on bit, on the enhanced variant only. Finally it pulses `done`. The clock-enable bits go low on the cycle a new request is accepted, so reprogramming never produces a short card clock pulse. A request of zero stops the card clock instead of starting a search.

The block also makes the card clock enable itself. This is a one-cycle pulse that repeats every prescaler × divider host cycles. Its counter reloads only from the settings that have been applied.

Top module: `sdclk_rate_divider`

## Requirements
- R1: The prescaler search starts at 1 when the enhanced variant flag is high and the DDR flag is low. In every other case it starts at 2.
- R2: The prescaler doubles while floor(host / prescaler / 16) is greater than the request and the prescaler is below 256.
- R3: With the prescaler fixed, the divider starts at 1 and increments while floor(host / prescaler / divider) is greater than the request and the divider is below 16.
- R4: `actual_rate` reports floor(host / prescaler / divider) once `done` pulses.
- R5: `pre_field` is the prescaler shifted right by 1 in SDR mode and by 2 in DDR mode. `div_field` is the divider minus 1. Both fields change only while `busy` is high.
- R6: A start with a request of zero sets `actual_rate` to 0, drops `clk_gates_on` and `force_clk_on`, and pulses `done` on the next cycle without going busy.
- R7: `clk_gates_on` goes low in the cycle after a non-zero request is accepted. It comes back high together with the new fields. `force_clk_on` then takes the value of the enhanced variant flag one cycle later.
- R8: `busy` is high from acceptance until `done`. `done` is a one-cycle pulse that is only seen with `busy` low. A start that arrives while `busy` is high is ignored and produces no result.
- R9: `card_clk_en` pulses exactly once every prescaler × divider cycles while `clk_gates_on` is high. It never pulses while `clk_gates_on` is low.
- R10: A very small request saturates at prescaler 256 and divider 16. This is the block's minimum rate of host / 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; accepted only while idle |
| host_rate | input | 32 | Host clock frequency in Hz |
| req_rate | input | 32 | Requested card clock frequency in Hz, 0 to stop |
| ddr_mode | input | 1 | Double-data-rate timing selected |
| enh_variant | input | 1 | Enhanced controller variant |
| busy | output | 1 | Search or apply in progress |
| done | output | 1 | One-cycle completion pulse |
| actual_rate | output | 32 | Achieved card clock frequency |
| pre_field | output | 8 | Encoded prescaler field |
| div_field | output | 4 | Encoded divider field (divider minus 1) |
| clk_gates_on | output | 1 | Clock-enable bits |
| force_clk_on | output | 1 | Force card clock on |
| card_clk_en | output | 1 | Divided card clock enable pulse |

## Verification
After a zero request, `done` and the stopped-clock outputs appear on the first edge after acceptance. After any other request, `busy` is high and the gates are low one cycle after acceptance. The result arrives a variable number of cycles later: one cycle per prescaler step, one per divider step, 32 for the rate quotient and two more to apply. The driver therefore checks the gates one cycle after start. A monitor then compares each queued expectation against the outputs only on the cycle `done` is high, so the check does not depend on a fixed latency. The enable rate is counted over a window that is a whole number of periods long, which gives an exact pulse count whatever the phase.

// File: rtl/sdclk_pkg.sv
// Shared types for the SD card clock rate divider.
package sdclk_pkg;
    // Sequencing states of the top-level control.
    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_SEARCH,
        CTL_QUOT,
        CTL_FORCE
    } ctl_state_t;
endpackage

// File: rtl/sdclk_search.sv
// Two-stage divider search: power-of-two prescaler, then linear divider.
// Each cycle makes one multiply-compare, which is equivalent to the
// floor-division test. Assumes host and req stay stable while searching.
module sdclk_search #(
    parameter int RATE_W  = 32,
    parameter int PRE_MAX = 256,
    parameter int DIV_MAX = 16,
    localparam int PRE_W  = $clog2(PRE_MAX) + 1,
    localparam int DIV_W  = $clog2(DIV_MAX) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [RATE_W-1:0] host,
    input  logic [RATE_W-1:0] req,
    input  logic [PRE_W-1:0]  pre_init,
    output logic              fin,
    output logic [PRE_W-1:0]  pre,
    output logic [DIV_W-1:0]  div
);
    localparam int PW = RATE_W + 1 + PRE_W + DIV_W;

    typedef enum logic [1:0] {S_IDLE, S_PRE, S_DIV} phase_t;
    phase_t phase;

    logic [PW-1:0] host_x, req_x, pre_lim, div_lim;

    // floor(h/(16p)) > r  <=>  h >= (r+1)*16*p ; same form for the divider
    assign host_x  = PW'(host);
    assign req_x   = PW'(req) + PW'(1);
    assign pre_lim = req_x * PW'(DIV_MAX) * PW'(pre);
    assign div_lim = req_x * PW'(pre) * PW'(div);

    // Step the search one comparison per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= S_IDLE;
            fin   <= 1'b0;
            pre   <= '0;
            div   <= '0;
        end else begin
            fin <= 1'b0;
            case (phase)
                S_IDLE: if (go) begin
                    pre   <= pre_init;
                    div   <= DIV_W'(1);
                    phase <= S_PRE;
                end
                S_PRE: begin
                    if (pre < PRE_W'(PRE_MAX) && host_x >= pre_lim) begin
                        pre <= pre << 1;
                    end else begin
                        div   <= DIV_W'(1);
                        phase <= S_DIV;
                    end
                end
                S_DIV: begin
                    if (div < DIV_W'(DIV_MAX) && host_x >= div_lim) begin
                        div <= div + DIV_W'(1);
                    end else begin
                        fin   <= 1'b1;
                        phase <= S_IDLE;
                    end
                end
                default: phase <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdclk_quotient.sv
// Serial restoring divider: one quotient bit per cycle, NUM_W cycles.
// Latches the divisor on go; assumes the divisor is non-zero.
module sdclk_quotient #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 13,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);
    logic [DEN_W-1:0] rem, den_q;
    logic [DEN_W:0]   rem_sh;
    logic [CNT_W-1:0] cnt;
    logic             active;

    assign rem_sh = {rem, quo[NUM_W-1]};

    // Shift in one dividend bit and subtract when the divisor fits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem    <= '0;
            den_q  <= '0;
            quo    <= '0;
            cnt    <= '0;
            active <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !active) begin
                rem    <= '0;
                den_q  <= den;
                quo    <= num;
                cnt    <= CNT_W'(NUM_W);
                active <= 1'b1;
            end else if (active) begin
                if (rem_sh >= {1'b0, den_q}) begin
                    rem <= DEN_W'(rem_sh - {1'b0, den_q});
                    quo <= {quo[NUM_W-2:0], 1'b1};
                end else begin
                    rem <= rem_sh[DEN_W-1:0];
                    quo <= {quo[NUM_W-2:0], 1'b0};
                end
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sdclk_enable_gen.sv
// Card clock enable: one pulse every 'period' cycles while run is high.
// Assumes period only changes while run is low.
module sdclk_enable_gen #(
    parameter int PER_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             en
);
    logic [PER_W-1:0] cnt;

    // Count host cycles and pulse at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            en  <= 1'b0;
        end else if (cnt >= period - PER_W'(1)) begin
            cnt <= '0;
            en  <= 1'b1;
        end else begin
            cnt <= cnt + PER_W'(1);
            en  <= 1'b0;
        end
    end
endmodule

// File: rtl/sdclk_rate_divider.sv
// SD card clock rate divider top: accepts a request, runs the divider
// search and rate quotient, then applies the fields, re-enables the
// clock and (on the enhanced variant) forces the card clock on.
module sdclk_rate_divider
    import sdclk_pkg::*;
#(
    parameter int RATE_W  = 32,
    parameter int PRE_MAX = 256,
    parameter int DIV_MAX = 16,
    localparam int PRE_W  = $clog2(PRE_MAX) + 1,
    localparam int DIV_W  = $clog2(DIV_MAX) + 1,
    localparam int PER_W  = PRE_W + DIV_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] host_rate,
    input  logic [RATE_W-1:0] req_rate,
    input  logic              ddr_mode,
    input  logic              enh_variant,
    output logic              busy,
    output logic              done,
    output logic [RATE_W-1:0] actual_rate,
    output logic [PRE_W-2:0]  pre_field,
    output logic [DIV_W-2:0]  div_field,
    output logic              clk_gates_on,
    output logic              force_clk_on,
    output logic              card_clk_en
);
    ctl_state_t        state;
    logic [RATE_W-1:0] host_q, req_q;
    logic              ddr_q, enh_q;
    logic              srch_go, srch_fin, quot_go, quot_fin;
    logic [PRE_W-1:0]  srch_pre, pre_init;
    logic [DIV_W-1:0]  srch_div;
    logic [RATE_W-1:0] quot;
    logic [PER_W-1:0]  applied_period;

    assign busy     = (state != CTL_IDLE);
    assign srch_go  = start && (state == CTL_IDLE) && (req_rate != '0);
    assign quot_go  = (state == CTL_SEARCH) && srch_fin;
    assign pre_init = (enh_variant && !ddr_mode) ? PRE_W'(1) : PRE_W'(2);

    sdclk_search #(.RATE_W(RATE_W), .PRE_MAX(PRE_MAX), .DIV_MAX(DIV_MAX)) u_search (
        .clk(clk), .rst_n(rst_n), .go(srch_go), .host(host_q), .req(req_q),
        .pre_init(pre_init), .fin(srch_fin), .pre(srch_pre), .div(srch_div)
    );

    sdclk_quotient #(.NUM_W(RATE_W), .DEN_W(PER_W)) u_quot (
        .clk(clk), .rst_n(rst_n), .go(quot_go), .num(host_q),
        .den(PER_W'(srch_pre) * PER_W'(srch_div)), .fin(quot_fin), .quo(quot)
    );

    sdclk_enable_gen #(.PER_W(PER_W)) u_en (
        .clk(clk), .rst_n(rst_n), .run(clk_gates_on),
        .period(applied_period), .en(card_clk_en)
    );

    // Sequence a request through search, quotient, apply and force-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= CTL_IDLE;
            host_q         <= '0;
            req_q          <= '0;
            ddr_q          <= 1'b0;
            enh_q          <= 1'b0;
            done           <= 1'b0;
            actual_rate    <= '0;
            pre_field      <= '0;
            div_field      <= '0;
            clk_gates_on   <= 1'b0;
            force_clk_on   <= 1'b0;
            applied_period <= PER_W'(1);
        end else begin
            done <= 1'b0;
            case (state)
                CTL_IDLE: if (start) begin
                    clk_gates_on <= 1'b0;
                    if (req_rate == '0) begin
                        actual_rate  <= '0;
                        force_clk_on <= 1'b0;
                        done         <= 1'b1;
                    end else begin
                        host_q <= host_rate;
                        req_q  <= req_rate;
                        ddr_q  <= ddr_mode;
                        enh_q  <= enh_variant;
                        state  <= CTL_SEARCH;
                    end
                end
                CTL_SEARCH: if (srch_fin) state <= CTL_QUOT;
                CTL_QUOT: if (quot_fin) begin
                    actual_rate    <= quot;
                    pre_field      <= ddr_q ? (PRE_W-1)'(srch_pre >> 2)
                                            : (PRE_W-1)'(srch_pre >> 1);
                    div_field      <= (DIV_W-1)'(srch_div - DIV_W'(1));
                    applied_period <= PER_W'(srch_pre) * PER_W'(srch_div);
                    clk_gates_on   <= 1'b1;
                    state          <= CTL_FORCE;
                end
                CTL_FORCE: begin
                    force_clk_on <= enh_q;
                    done         <= 1'b1;
                    state        <= CTL_IDLE;
                end
                default: state <= CTL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdclk_rate_divider_chk.sv
// Property checker for sdclk_rate_divider, attached by bind below.
module sdclk_rate_divider_chk #(
    parameter int RATE_W = 32,
    parameter int PF_W   = 8,
    parameter int DF_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [RATE_W-1:0] req_rate,
    input logic              busy,
    input logic              done,
    input logic [RATE_W-1:0] actual_rate,
    input logic [PF_W-1:0]   pre_field,
    input logic [DF_W-1:0]   div_field,
    input logic              clk_gates_on,
    input logic              force_clk_on,
    input logic              card_clk_en
);
    a_r6_zero_stops_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && req_rate == '0) |=>
        (done && !clk_gates_on && !force_clk_on && actual_rate == '0));

    a_r7_gates_low_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && req_rate != '0) |=> (busy && !clk_gates_on));

    a_r7_force_after_gates: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_clk_on) |-> $past(clk_gates_on));

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r5_fields_change_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pre_field) || !$stable(div_field)) |-> $past(busy));

    a_r9_enable_needs_gates: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk_en |-> $past(clk_gates_on));
endmodule

bind sdclk_rate_divider sdclk_rate_divider_chk #(
    .RATE_W(RATE_W), .PF_W(PRE_W - 1), .DF_W(DIV_W - 1)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate),
    .busy(busy), .done(done), .actual_rate(actual_rate),
    .pre_field(pre_field), .div_field(div_field),
    .clk_gates_on(clk_gates_on), .force_clk_on(force_clk_on),
    .card_clk_en(card_clk_en)
);

// File: tb/sdclk_rate_divider_tb.sv
// Scoreboard bench: the driver queues expected results, the monitor
// compares them on each done pulse.
module sdclk_rate_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] host_rate = '0;
    logic [31:0] req_rate = '0;
    logic        ddr_mode = 1'b0;
    logic        enh_variant = 1'b0;
    logic        busy, done, clk_gates_on, force_clk_on, card_clk_en;
    logic [31:0] actual_rate;
    logic [7:0]  pre_field;
    logic [3:0]  div_field;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        longint act;
        longint pre_f;
        longint div_f;
        bit     frc;
        string  tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    sdclk_rate_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .host_rate(host_rate),
        .req_rate(req_rate), .ddr_mode(ddr_mode), .enh_variant(enh_variant),
        .busy(busy), .done(done), .actual_rate(actual_rate),
        .pre_field(pre_field), .div_field(div_field),
        .clk_gates_on(clk_gates_on), .force_clk_on(force_clk_on),
        .card_clk_en(card_clk_en)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare one expectation per done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(longint'(actual_rate) == e.act, {e.tag, " R4 achieved rate"},
                      longint'(actual_rate), e.act);
                check(longint'(pre_field) == e.pre_f, {e.tag, " R5 prescaler field"},
                      longint'(pre_field), e.pre_f);
                check(longint'(div_field) == e.div_f, {e.tag, " R5 divider field"},
                      longint'(div_field), e.div_f);
                check(force_clk_on == e.frc, {e.tag, " R7 force-on"},
                      longint'(force_clk_on), longint'(e.frc));
            end
        end
    end

    // Driver: compute the expected result from the rules and issue a request.
    task automatic run_case(input longint h, input longint r, input bit ddr,
                            input bit enh, input string tag, input bit poke_busy);
        exp_t e;
        longint pre, dv;
        pre = (enh && !ddr) ? 1 : 2;
        while ((h / pre / 16) > r && pre < 256) pre = pre * 2;
        dv = 1;
        while ((h / pre / dv) > r && dv < 16) dv = dv + 1;
        if (r == 0) begin
            e.act = 0; e.pre_f = longint'(pre_field); e.div_f = longint'(div_field); e.frc = 1'b0;
        end else begin
            e.act = h / pre / dv;
            e.pre_f = ddr ? (pre >> 2) : (pre >> 1);
            e.div_f = dv - 1;
            e.frc = enh;
        end
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        host_rate = 32'(h); req_rate = 32'(r); ddr_mode = ddr; enh_variant = enh;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (r != 0) begin
            check(busy && !clk_gates_on, {tag, " R7 gates low while busy"},
                  longint'(clk_gates_on), 0);
            if (poke_busy) begin
                req_rate = 32'd7; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        check(clk_gates_on == (r != 0), {tag, " R7 gates state after done"},
              longint'(clk_gates_on), longint'(r != 0));
    endtask

    task automatic count_en(input int cycles, input longint exp, input string tag);
        int cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (card_clk_en) cnt++;
        end
        check(longint'(cnt) == exp, tag, longint'(cnt), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !clk_gates_on && !force_clk_on && !card_clk_en
              && actual_rate == 0, "R8 reset state", longint'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case(200000000, 400000, 1'b0, 1'b0, "R1 R2 R3 base", 1'b0);
        run_case(200000000, 400000, 1'b0, 1'b1, "R1 enhanced start", 1'b0);
        run_case(100000000, 25000000, 1'b1, 1'b1, "R1 R5 ddr", 1'b0);
        run_case(50000000, 60000000, 1'b0, 1'b1, "R3 request above host", 1'b0);
        run_case(100000000, 1, 1'b0, 1'b0, "R10 minimum rate", 1'b0);
        run_case(96, 10, 1'b0, 1'b1, "R8 start ignored while busy", 1'b1);
        repeat (5) @(negedge clk);
        check(sb.size() == 0 && !busy, "R8 no extra result", longint'(busy), 0);
        count_en(36, 4, "R9 enable period 9");
        run_case(48000000, 400000, 1'b1, 1'b0, "R2 R5 ddr sdr-variant", 1'b0);
        run_case(0, 0, 1'b0, 1'b1, "R6 zero request", 1'b0);
        check(!force_clk_on && actual_rate == 0, "R6 clock stopped",
              longint'(force_clk_on), 0);
        count_en(40, 0, "R9 no enable when gated");
        run_case(64, 16, 1'b0, 1'b1, "R4 exact rate", 1'b0);
        count_en(40, 10, "R9 enable period 4");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule